// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of asynchronous external interrupt inputs (1 to 32) into one interrupt request for the processor. A separate non-maskable request is also produced, and it is taken from line 0 alone. Each input is brought into the clock domain by a flop chain. Each line is then sensed as either a level or an edge. The polarity or edge direction is chosen per line. A per-line state machine holds the pending condition. The processor output is raised whenever a pending line is also unmasked.

Software drives the block through a plain register port with 32-bit words. The mask is never written directly. It is raised through a set register and lowered through an unset register, so that separate software contexts can change different lines without a read-modify-write. Latched edge events are acknowledged through a write-one-to-clear register. Only implemented lines hold state. Software can therefore find the line count by writing all ones to the sense-select register and reading it back.

Each line runs a two-state machine with states `LINE_IDLE` and `LINE_PENDING`:
- **arm**: `LINE_IDLE` to `LINE_PENDING` when the line's trigger condition is seen.
- **retire**: `LINE_PENDING` to `LINE_IDLE`. In edge sense this happens on an acknowledge with no fresh edge in the same cycle. In level sense it happens when the level goes inactive.
- **hold**: any other case keeps the current state.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the mask, sense-select, edge-direction, level-polarity and NMI-control registers all read 0, every line is idle, and `cpu_irq` and `nmi_out` are low.
- R2: A write to offset 0x00 sets each mask bit whose data bit is 1. A write to offset 0x04 clears each mask bit whose data bit is 1. Zero data bits leave the mask as it was. The mask reads at offset 0x08.
- R3: In edge sense, a write of 1 to a bit at offset 0x10 returns a pending line to idle, provided no new edge is detected in that same cycle.
- R4: A line is in edge sense when its sense-select bit (offset 0x14) is 0. In edge sense, an edge-direction bit (offset 0x18) of 1 selects rising edges and 0 selects falling edges. Suppose an input changes before clock edge k and stays there. The line's status (read at offset 0x0C, bit i = line i) is then 1 from clock edge k+2 on.
- R5: In edge sense a pending line stays pending through later input changes until it is acknowledged. An acknowledge in the same cycle as a new detected edge leaves it pending.
- R6: A line is in level sense when its sense-select bit is 1. In level sense, a level-polarity bit (offset 0x1C) of 1 means active-high and 0 means active-low. Status follows the active level with the same two-cycle synchroniser delay, and an acknowledge has no effect while the level is active.
- R7: `cpu_irq` is high exactly when some line is both pending and unmasked.
- R8: Bit 0 of the NMI-control register (offset 0x24, read and write) enables `nmi_out`. `nmi_out` equals line 0's pending state gated by that bit and does not depend on the mask.
- R9: Register bits at positions NUM_LINES and above read as 0 and ignore writes. With NUM_LINES lines, writing all ones to offset 0x14 reads back as 2^NUM_LINES - 1.
- R10: Reads of offsets 0x00, 0x04, 0x10 and unmapped offsets return 0. Writes to the mask (0x08) and status (0x0C) offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ext_in | input | NUM_LINES | Asynchronous external interrupt inputs |
| cpu_irq | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable request from line 0 |

## Verification
A line machine left in the wrong state shows up on the next clock in two places: in the status word, and in `cpu_irq` whenever that line is unmasked. For line 0 it also shows in `nmi_out` once NMI is enabled. Because of this, the bench compares both outputs against a behavioural model on every cycle and reads the status word after each stimulus step. An edge that is missed or counted twice cannot hide for longer than the next comparison. Faults in the mask, in the polarity bits or in the clipping of unimplemented bits are caught when those registers are read back, with expected values worked out directly from the requirements.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_SET   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_UNSET = 8'h04;
    localparam logic [REG_AW-1:0] OFS_MASK  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_ACK   = 8'h10;
    localparam logic [REG_AW-1:0] OFS_SENSE = 8'h14;
    localparam logic [REG_AW-1:0] OFS_EDIR  = 8'h18;
    localparam logic [REG_AW-1:0] OFS_LPOL  = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_NMI   = 8'h24;

    typedef enum logic {
        LINE_IDLE    = 1'b0,
        LINE_PENDING = 1'b1
    } line_state_e;
endpackage

// File: rtl/xirq_sync.sv
`timescale 1ns/1ps
module xirq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xirq_line.sv
`timescale 1ns/1ps
module xirq_line
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic sense_lvl_i,
    input  logic edir_rise_i,
    input  logic lpol_high_i,
    input  logic ack_i,
    output logic pending_o
);
    line_state_e state_q, state_d;
    logic prev_q;
    logic rise, fall, edge_hit, lvl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign rise     = smp_i & ~prev_q;
    assign fall     = ~smp_i & prev_q;
    assign edge_hit = edir_rise_i ? rise : fall;
    assign lvl_hit  = lpol_high_i ? smp_i : ~smp_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE: begin
                if (sense_lvl_i ? lvl_hit : edge_hit) state_d = LINE_PENDING;
            end
            LINE_PENDING: begin
                if (sense_lvl_i) begin
                    if (!lvl_hit) state_d = LINE_IDLE;
                end else if (ack_i && !edge_hit) begin
                    state_d = LINE_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending_o = (state_q == LINE_PENDING);
    end

    a_r4_edge_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_lvl_i && edge_hit) |=> pending_o);
    a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_lvl_i && pending_o && !ack_i) |=> pending_o);
    a_r3_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_lvl_i && ack_i && !edge_hit) |=> !pending_o);
    a_r6_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        sense_lvl_i |=> (pending_o == $past(lvl_hit)));
endmodule

// File: rtl/xirq_regs.sv
`timescale 1ns/1ps
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [REG_DW-1:0]    bus_wdata,
    output logic [REG_DW-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] status_i,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] sense_o,
    output logic [NUM_LINES-1:0] edir_o,
    output logic [NUM_LINES-1:0] lpol_o,
    output logic [NUM_LINES-1:0] ack_o,
    output logic                 nmi_en_o
);
    localparam int LW = NUM_LINES;

    logic          wr_en;
    logic [LW-1:0] wbits;
    logic [LW-1:0] mask_q, sense_q, edir_q, lpol_q;
    logic          nmi_en_q;

    assign wr_en = bus_valid & bus_write;
    assign wbits = bus_wdata[LW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            sense_q  <= '0;
            edir_q   <= '0;
            lpol_q   <= '0;
            nmi_en_q <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_SET:   mask_q   <= mask_q | wbits;
                OFS_UNSET: mask_q   <= mask_q & ~wbits;
                OFS_SENSE: sense_q  <= wbits;
                OFS_EDIR:  edir_q   <= wbits;
                OFS_LPOL:  lpol_q   <= wbits;
                OFS_NMI:   nmi_en_q <= bus_wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        ack_o = (wr_en && bus_addr == OFS_ACK) ? wbits : '0;
    end

    always_comb begin
        case (bus_addr)
            OFS_MASK:  bus_rdata = REG_DW'(mask_q);
            OFS_STAT:  bus_rdata = REG_DW'(status_i);
            OFS_SENSE: bus_rdata = REG_DW'(sense_q);
            OFS_EDIR:  bus_rdata = REG_DW'(edir_q);
            OFS_LPOL:  bus_rdata = REG_DW'(lpol_q);
            OFS_NMI:   bus_rdata = REG_DW'(nmi_en_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign mask_o   = mask_q;
    assign sense_o  = sense_q;
    assign edir_o   = edir_q;
    assign lpol_o   = lpol_q;
    assign nmi_en_o = nmi_en_q;

    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));
    a_r2_unset_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_UNSET) |=> ((mask_q & $past(wbits)) == '0));
    a_r2_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(mask_q));
    a_r8_nmi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_NMI) |=> (nmi_en_q == $past(bus_wdata[0])));
endmodule

// File: rtl/xirq_ctrl.sv
`timescale 1ns/1ps
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [REG_DW-1:0]    bus_wdata,
    output logic [REG_DW-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] ext_in,
    output logic                 cpu_irq,
    output logic                 nmi_out
);
    logic [NUM_LINES-1:0] smp, status, mask, sense, edir, lpol, ack;
    logic                 nmi_en;

    xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_in),
        .sync_o  (smp)
    );

    xirq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_i  (status),
        .mask_o    (mask),
        .sense_o   (sense),
        .edir_o    (edir),
        .lpol_o    (lpol),
        .ack_o     (ack),
        .nmi_en_o  (nmi_en)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xirq_line u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .smp_i       (smp[i]),
            .sense_lvl_i (sense[i]),
            .edir_rise_i (edir[i]),
            .lpol_high_i (lpol[i]),
            .ack_i       (ack[i]),
            .pending_o   (status[i])
        );
    end

    assign cpu_irq = |(status & mask);
    assign nmi_out = status[0] & nmi_en;

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !cpu_irq);
    a_r8_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_en) |-> !nmi_out);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (status == '0 && !cpu_irq && !nmi_out));
endmodule

// File: tb/tb_xirq_ctrl.sv
`timescale 1ns/1ps
module tb_xirq_ctrl;
    localparam int NL = 20;
    localparam logic [31:0] LM = 32'hFFFF_FFFF >> (32 - NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] ext_in = '0;
    logic          cpu_irq, nmi_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xirq_ctrl #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_in(ext_in), .cpu_irq(cpu_irq), .nmi_out(nmi_out)
    );

    // Behavioural reference, one bit at a time
    bit [31:0] m_s1, m_s2, m_prev, m_stat, m_mask, m_sense, m_edir, m_lpol;
    bit        m_nmi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_mask = 0;
            m_sense = 0; m_edir = 0; m_lpol = 0; m_nmi = 0;
        end else begin
            bit [31:0] clr, nstat;
            bit we;
            we = bus_valid && bus_write;
            clr = (we && bus_addr == 8'h10) ? (bus_wdata & LM) : 32'h0;
            nstat = 0;
            for (int i = 0; i < NL; i++) begin
                bit s, p, hit;
                s = m_s2[i]; p = m_prev[i];
                if (m_sense[i]) begin
                    hit = m_lpol[i] ? s : !s;
                    nstat[i] = hit;
                end else begin
                    hit = m_edir[i] ? (s && !p) : (!s && p);
                    nstat[i] = hit || (m_stat[i] && !clr[i]);
                end
            end
            m_stat = nstat;
            if (we) begin
                case (bus_addr)
                    8'h00: m_mask = m_mask | (bus_wdata & LM);
                    8'h04: m_mask = m_mask & ~bus_wdata;
                    8'h14: m_sense = bus_wdata & LM;
                    8'h18: m_edir = bus_wdata & LM;
                    8'h1C: m_lpol = bus_wdata & LM;
                    8'h24: m_nmi = bus_wdata[0];
                    default: ;
                endcase
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = 32'(ext_in);
        end
    end

    function automatic bit [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h08: return m_mask;
            8'h0C: return m_stat;
            8'h14: return m_sense;
            8'h18: return m_edir;
            8'h1C: return m_lpol;
            8'h24: return {31'h0, m_nmi};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Every cycle: outputs against the reference (R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(32'(cpu_irq), 32'(|(m_stat & m_mask)), "R7 cpu_irq vs model");
            chk(32'(nmi_out), 32'(m_stat[0] & m_nmi), "R8 nmi_out vs model");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_valid = 1'b1; bus_write = 1'b0;
        #1;
        chk(bus_rdata, exp, tag);
        chk(bus_rdata, model_read(a), {tag, " (model)"});
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(8'h08, 0, "R1 mask"); rd(8'h14, 0, "R1 sense"); rd(8'h18, 0, "R1 edir");
        rd(8'h1C, 0, "R1 lpol"); rd(8'h24, 0, "R1 nmi ctl"); rd(8'h0C, 0, "R1 status");
        chk(32'(cpu_irq), 0, "R1 cpu_irq"); chk(32'(nmi_out), 0, "R1 nmi_out");

        // R9 line count discovery and clipping
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, 32'h000F_FFFF, "R9 sense all ones");
        wr(8'h14, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h0C, 0, "R3 clear all");
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h08, 32'h000F_FFFF, "R9 mask clipped");

        // R2 set/unset
        wr(8'h04, 32'h0000_00F0); rd(8'h08, 32'h000F_FF0F, "R2 unset some");
        wr(8'h04, 32'h0); rd(8'h08, 32'h000F_FF0F, "R2 unset zero keeps");
        wr(8'h00, 32'h0); rd(8'h08, 32'h000F_FF0F, "R2 set zero keeps");
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h08, 0, "R2 unset all");
        wr(8'h00, 32'h6); rd(8'h08, 32'h6, "R2 set lines 1,2");

        // R4 edge sense: line1 rising, line2 falling
        wr(8'h18, 32'h2);
        ext_in[1] = 1'b1; ext_in[2] = 1'b1;
        cyc(2); rd(8'h0C, 0, "R4 not yet after two edges");
        cyc(1); rd(8'h0C, 32'h2, "R4 rising on line1 only");
        ext_in[2] = 1'b0;
        cyc(3); rd(8'h0C, 32'h6, "R4 falling on line2");

        // R3 acknowledge
        wr(8'h10, 32'h2); rd(8'h0C, 32'h4, "R3 ack line1");
        wr(8'h10, 32'h4); rd(8'h0C, 0, "R3 ack line2");
        chk(32'(cpu_irq), 0, "R7 quiet after acks");

        // R5 persistence and ack/edge collision
        ext_in[1] = 1'b0; cyc(3); rd(8'h0C, 0, "R4 wrong edge ignored");
        ext_in[1] = 1'b1; cyc(3); rd(8'h0C, 32'h2, "R4 rising again");
        ext_in[1] = 1'b0; cyc(5); rd(8'h0C, 32'h2, "R5 held through falling");
        ext_in[1] = 1'b1; cyc(2);
        wr(8'h10, 32'h2); rd(8'h0C, 32'h2, "R5 edge wins over ack");
        wr(8'h10, 32'h2); rd(8'h0C, 0, "R3 ack after collision");

        // R6 level sense: line3 active high, line4 active low
        wr(8'h1C, 32'h8); wr(8'h14, 32'h18); wr(8'h00, 32'h18);
        rd(8'h0C, 32'h10, "R6 active-low line4 pending");
        wr(8'h10, 32'h10); rd(8'h0C, 32'h10, "R6 ack ignored while active");
        ext_in[3] = 1'b1; cyc(3); rd(8'h0C, 32'h18, "R6 active-high line3");
        ext_in[3] = 1'b0; cyc(3); rd(8'h0C, 32'h10, "R6 line3 released");
        ext_in[4] = 1'b1; cyc(3); rd(8'h0C, 0, "R6 line4 released");

        // R8 NMI from line 0, mask independent
        wr(8'h1C, 32'h9); wr(8'h14, 32'h19); wr(8'h04, 32'h1);
        wr(8'h24, 32'h1); rd(8'h24, 32'h1, "R8 nmi ctl reads");
        ext_in[0] = 1'b1; cyc(3);
        chk(32'(nmi_out), 1, "R8 nmi with line0 masked");
        chk(32'(cpu_irq), 0, "R7 masked line0 quiet");
        wr(8'h24, 32'h0); chk(32'(nmi_out), 0, "R8 nmi disabled");
        wr(8'h24, 32'h1); chk(32'(nmi_out), 1, "R8 nmi re-enabled");
        ext_in[0] = 1'b0; cyc(3); chk(32'(nmi_out), 0, "R8 nmi follows line0");

        // R10 decode
        rd(8'h00, 0, "R10 set reads 0"); rd(8'h04, 0, "R10 unset reads 0");
        rd(8'h10, 0, "R10 ack reads 0"); rd(8'h20, 0, "R10 gap reads 0");
        rd(8'h28, 0, "R10 beyond reads 0");
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, 32'h1E, "R10 mask not writable");
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, 0, "R10 status not writable");
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 32'h000F_FFFF, "R9 edir clipped");
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h000F_FFFF, "R9 lpol clipped");

        // Mixed traffic against the model (R4 R5 R6 R7 R8)
        for (int c = 0; c < 400; c++) begin
            logic [31:0] r, d;
            logic [7:0]  addrs [9];
            addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h24};
            r = $urandom;
            rd(addrs[r[3:0] % 9], model_read(addrs[r[3:0] % 9]), "R7 mixed readback");
            d = $urandom;
            if (r[7:4] == 4'h0) ext_in = d[NL-1:0];
            else if (r[7:4] < 4'h4) ext_in[r[12:8] % NL] = ~ext_in[r[12:8] % NL];
            if (r[15:14] == 2'b00) begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr = addrs[r[19:16] % 9]; bus_wdata = $urandom;
            end
            cyc(1);
            bus_valid = 1'b0; bus_write = 1'b0;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule